// File: doc/BRIEF.md
# Flash Command Unlock Decoder

This block sits in front of a byte-wide flash array model and turns a stream of bus writes into commands. Each write offers an address and a data byte on a single-cycle valid strobe. A command is two fixed key writes followed by an operation byte. The block answers with one-cycle pulses for return-to-array-read, identifier mode entry and program start. For a program command it also captures the target address and data byte from the write that follows the operation byte.

While identifier mode is active, reads return the manufacturer code, a parameterised device code, or the protection flag of the block named by the top address bits. Protection flags live in a small RAM that a test port loads. A controller alongside the block reports two things through inputs: whether it is busy, and whether an erase or an erase suspension is under way. These inputs gate which commands are accepted.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Three writes enter identifier mode: AAh to address 555h, then 55h to 2AAh, then 90h to 555h. The write of 90h raises `id_pulse` for one cycle and sets `id_mode` in the cycle after that write.
- R2: Key and command address matching uses only address bits 11:0. The same sequences with any value in bits 19:12 behave identically.
- R3: After the two key writes, A0h written to 555h arms a program operation. The next write of any address and data raises `prog_start` for one cycle in the cycle after that write, with `prog_addr` and `prog_data` equal to that write's address and data.
- R4: If `busy` is high when A0h is written, the program is not armed, and the following write produces no `prog_start`.
- R5: A write of F0h at any address acts as return-to-read, whether it comes from idle or directly after the two key writes. It raises `reset_pulse` for one cycle and clears `id_mode`.
- R6: A return-to-read write made while `erase_active` is high produces no `reset_pulse` and leaves `id_mode` unchanged.
- R7: A write that breaks the sequence returns the decoder to idle and raises no pulse. This covers a wrong second key, or an unknown operation byte or wrong command address after the keys. A following lone 55h at 2AAh or 90h at 555h then also does nothing.
- R8: A read presented with `rd_valid` raises `rd_ack` in the next cycle. In identifier mode, address bits 1:0 = 00 return 20h and bits 1:0 = 01 return the `DEV_CODE` parameter (default D2h), with `rd_id` high.
- R9: In identifier mode, a read with bits 1:0 = 10 and bit 6 = 0 returns 01h if the block addressed by bits 19:13 is protected and 00h otherwise. Protection flags are written through `prot_we`/`prot_blk`/`prot_set`.
- R10: Outside identifier mode, a read returns `rd_id` = 0 and `rd_data` = 00h.
- R11: In identifier mode, a read with bits 1:0 = 11, or with bits 1:0 = 10 and bit 6 = 1, returns 00h.
- R12: At most one of `reset_pulse`, `id_pulse` and `prog_start` is high in any cycle. `id_pulse` and `prog_start` never stay high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write cycle present this clock |
| wr_addr | input | 20 | Write address |
| wr_data | input | 8 | Write data byte |
| busy | input | 1 | Controller is programming or erasing |
| erase_active | input | 1 | Erase or erase suspension under way |
| rd_valid | input | 1 | Read request this clock |
| rd_addr | input | 20 | Read address |
| rd_data | output | 8 | Identifier read data, one cycle after request |
| rd_ack | output | 1 | Read data valid |
| rd_id | output | 1 | Read was served from identifier space |
| prot_we | input | 1 | Protection flag write enable |
| prot_blk | input | 7 | Block index for the flag write |
| prot_set | input | 1 | Flag value to write |
| reset_pulse | output | 1 | Return-to-read command accepted |
| id_pulse | output | 1 | Identifier mode command accepted |
| prog_start | output | 1 | Program operation started |
| prog_addr | output | 20 | Captured program address |
| prog_data | output | 8 | Captured program data |
| id_mode | output | 1 | Identifier mode active |

## Verification
The hardest state to reach is a broken sequence followed by the tail of a valid one. The decoder must not resume mid-sequence, and the busy or erase gate must act on exactly the write that carries the operation byte. Directed cases drive these interleavings directly. A long random run then draws each write from the key, operation and noise patterns, with random high address bits, occasional busy and erase flags, and interleaved identifier reads. A bench-side sequence model predicts every pulse and read value.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam int KEY_W = 12;
  localparam logic [KEY_W-1:0] KEY1_ADDR = 12'h555;
  localparam logic [KEY_W-1:0] KEY2_ADDR = 12'h2AA;
  localparam logic [KEY_W-1:0] OP_ADDR   = 12'h555;
  localparam logic [7:0] KEY1_DATA = 8'hAA;
  localparam logic [7:0] KEY2_DATA = 8'h55;
  localparam logic [7:0] OP_RETURN = 8'hF0;
  localparam logic [7:0] OP_IDENT  = 8'h90;
  localparam logic [7:0] OP_PROG   = 8'hA0;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_KEY1,
    SEQ_KEY2,
    SEQ_PROG
  } seq_t;

  typedef enum logic [1:0] {
    RK_NONE,
    RK_MFR,
    RK_DEV,
    RK_PROT
  } rkind_t;
endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  input  logic              erase_active,
  output logic              reset_pulse,
  output logic              id_pulse,
  output logic              prog_start,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              id_mode
);
  seq_t st;
  logic [KEY_W-1:0] key_a;
  logic is_ret, op_ok, ret_ok;

  assign key_a  = wr_addr[KEY_W-1:0];
  assign is_ret = (wr_data == OP_RETURN);
  assign op_ok  = (key_a == OP_ADDR);
  assign ret_ok = wr_valid && is_ret && !erase_active &&
                  ((st == SEQ_IDLE) || (st == SEQ_KEY2));

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= SEQ_IDLE;
      reset_pulse <= 1'b0;
      id_pulse    <= 1'b0;
      prog_start  <= 1'b0;
      prog_addr   <= '0;
      prog_data   <= '0;
      id_mode     <= 1'b0;
    end else begin
      reset_pulse <= 1'b0;
      id_pulse    <= 1'b0;
      prog_start  <= 1'b0;
      if (ret_ok) begin
        reset_pulse <= 1'b1;
        id_mode     <= 1'b0;
      end
      if (wr_valid) begin
        unique case (st)
          SEQ_IDLE: begin
            if (!is_ret && key_a == KEY1_ADDR && wr_data == KEY1_DATA)
              st <= SEQ_KEY1;
          end
          SEQ_KEY1: begin
            st <= (key_a == KEY2_ADDR && wr_data == KEY2_DATA) ? SEQ_KEY2 : SEQ_IDLE;
          end
          SEQ_KEY2: begin
            st <= SEQ_IDLE;
            if (op_ok && wr_data == OP_IDENT) begin
              id_pulse <= 1'b1;
              id_mode  <= 1'b1;
            end else if (op_ok && wr_data == OP_PROG && !busy) begin
              st <= SEQ_PROG;
            end
          end
          SEQ_PROG: begin
            st         <= SEQ_IDLE;
            prog_start <= 1'b1;
            prog_addr  <= wr_addr;
            prog_data  <= wr_data;
          end
          default: st <= SEQ_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/flash_prot_ram.sv
module flash_prot_ram #(
  parameter int BLK_W = 7
) (
  input  logic             clk,
  input  logic             we,
  input  logic [BLK_W-1:0] waddr,
  input  logic             wbit,
  input  logic [BLK_W-1:0] raddr,
  output logic             rbit
);
  localparam int NBLK = 1 << BLK_W;
  logic mem [NBLK];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wbit;
    rbit <= mem[raddr];
  end
endmodule

// File: rtl/flash_id_read.sv
module flash_id_read
  import flash_cmd_pkg::*;
#(
  parameter logic [7:0] MFR_CODE = 8'h20,
  parameter logic [7:0] DEV_CODE = 8'hD2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd_valid,
  input  logic       a0,
  input  logic       a1,
  input  logic       a6,
  input  logic       id_mode,
  input  logic       prot_bit,
  output logic [7:0] rd_data,
  output logic       rd_ack,
  output logic       rd_id
);
  rkind_t kind_q, kind_d;

  always_comb begin
    kind_d = RK_NONE;
    if (!a1 && !a0)           kind_d = RK_MFR;
    else if (!a1 && a0)       kind_d = RK_DEV;
    else if (a1 && !a0 && !a6) kind_d = RK_PROT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ack <= 1'b0;
      rd_id  <= 1'b0;
      kind_q <= RK_NONE;
    end else begin
      rd_ack <= rd_valid;
      if (rd_valid) begin
        rd_id  <= id_mode;
        kind_q <= id_mode ? kind_d : RK_NONE;
      end
    end
  end

  always_comb begin
    unique case (kind_q)
      RK_MFR:  rd_data = MFR_CODE;
      RK_DEV:  rd_data = DEV_CODE;
      RK_PROT: rd_data = {7'd0, prot_bit};
      default: rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int         ADDR_W   = 20,
  parameter int         BLK_W    = 7,
  parameter logic [7:0] MFR_CODE = 8'h20,
  parameter logic [7:0] DEV_CODE = 8'hD2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              busy,
  input  logic              erase_active,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              rd_ack,
  output logic              rd_id,
  input  logic              prot_we,
  input  logic [BLK_W-1:0]  prot_blk,
  input  logic              prot_set,
  output logic              reset_pulse,
  output logic              id_pulse,
  output logic              prog_start,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic              id_mode
);
  localparam int BLK_LSB = ADDR_W - BLK_W;

  logic prot_bit;
  logic unused_rd_bits;
  assign unused_rd_bits = ^{rd_addr[BLK_LSB-1:7], rd_addr[5:2]};

  flash_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk, .rst, .wr_valid, .wr_addr, .wr_data, .busy, .erase_active,
    .reset_pulse, .id_pulse, .prog_start, .prog_addr, .prog_data, .id_mode
  );

  flash_prot_ram #(.BLK_W(BLK_W)) u_prot (
    .clk   (clk),
    .we    (prot_we),
    .waddr (prot_blk),
    .wbit  (prot_set),
    .raddr (rd_addr[ADDR_W-1:BLK_LSB]),
    .rbit  (prot_bit)
  );

  flash_id_read #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_idrd (
    .clk      (clk),
    .rst      (rst),
    .rd_valid (rd_valid),
    .a0       (rd_addr[0]),
    .a1       (rd_addr[1]),
    .a6       (rd_addr[6]),
    .id_mode  (id_mode),
    .prot_bit (prot_bit),
    .rd_data  (rd_data),
    .rd_ack   (rd_ack),
    .rd_id    (rd_id)
  );
endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_valid,
  input logic [7:0] wr_data,
  input logic       erase_active,
  input logic       rd_valid,
  input logic [7:0] rd_data,
  input logic       rd_ack,
  input logic       rd_id,
  input logic       reset_pulse,
  input logic       id_pulse,
  input logic       prog_start,
  input logic       id_mode
);
  p_onehot_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reset_pulse, id_pulse, prog_start}));
  p_prog_single_r12: assert property (@(posedge clk) disable iff (rst)
    prog_start |=> !prog_start);
  p_id_single_r12: assert property (@(posedge clk) disable iff (rst)
    id_pulse |=> !id_pulse);
  p_prog_from_write_r3: assert property (@(posedge clk) disable iff (rst)
    prog_start |-> $past(wr_valid));
  p_mode_rise_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(id_mode) |-> id_pulse);
  p_mode_fall_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(id_mode) |-> reset_pulse);
  p_erase_block_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && erase_active && wr_data == 8'hF0) |=> (!reset_pulse && $stable(id_mode)));
  p_read_ack_r8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> rd_ack);
  p_array_read_r10: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && !rd_id) |-> rd_data == 8'h00);
endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk u_chk (
  .clk, .rst, .wr_valid, .wr_data, .erase_active, .rd_valid, .rd_data,
  .rd_ack, .rd_id, .reset_pulse, .id_pulse, .prog_start, .id_mode
);

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
  localparam int CLK_P = 10;
  localparam logic [7:0] DEV = 8'hD2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        busy = 1'b0;
  logic        erase_active = 1'b0;
  logic        rd_valid = 1'b0;
  logic [19:0] rd_addr = '0;
  logic [7:0]  rd_data;
  logic        rd_ack, rd_id;
  logic        prot_we = 1'b0;
  logic [6:0]  prot_blk = '0;
  logic        prot_set = 1'b0;
  logic        reset_pulse, id_pulse, prog_start, id_mode;
  logic [19:0] prog_addr;
  logic [7:0]  prog_data;

  int n_chk = 0;
  int n_err = 0;
  int m_st = 0;
  bit m_as = 0;
  bit m_prot [128];

  always #(CLK_P/2) clk = ~clk;

  flash_cmd_decoder u_dut (
    .clk, .rst, .wr_valid, .wr_addr, .wr_data, .busy, .erase_active,
    .rd_valid, .rd_addr, .rd_data, .rd_ack, .rd_id,
    .prot_we, .prot_blk, .prot_set,
    .reset_pulse, .id_pulse, .prog_start, .prog_addr, .prog_data, .id_mode
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected read value from the requirements
  function automatic logic [7:0] exp_rd(input logic [19:0] a);
    if (!m_as) return 8'h00;                            // R10
    if (a[1:0] == 2'b00) return 8'h20;                  // R8
    if (a[1:0] == 2'b01) return DEV;                    // R8
    if (a[1:0] == 2'b10 && !a[6]) return {7'd0, m_prot[a[19:13]]}; // R9
    return 8'h00;                                       // R11
  endfunction

  task automatic do_wr(input logic [19:0] a, input logic [7:0] d, input bit bz, input bit er, input string req);
    bit e_r = 0, e_i = 0, e_p = 0;
    int nst = m_st;
    logic [11:0] k = a[11:0];
    case (m_st)
      0: if (d == 8'hF0) e_r = !er; else if (k == 12'h555 && d == 8'hAA) nst = 1;
      1: nst = (k == 12'h2AA && d == 8'h55) ? 2 : 0;
      2: begin
        nst = 0;
        if (d == 8'hF0) e_r = !er;
        else if (k == 12'h555 && d == 8'h90) e_i = 1;
        else if (k == 12'h555 && d == 8'hA0 && !bz) nst = 3;
      end
      default: begin e_p = 1; nst = 0; end
    endcase
    m_st = nst;
    if (e_r) m_as = 0;
    if (e_i) m_as = 1;
    wr_valid = 1; wr_addr = a; wr_data = d; busy = bz; erase_active = er;
    @(negedge clk);
    wr_valid = 0; busy = 0; erase_active = 0;
    chk({reset_pulse, id_pulse, prog_start} == {e_r, e_i, e_p}, req,
        {reset_pulse, id_pulse, prog_start}, {e_r, e_i, e_p});
    chk(id_mode == m_as, req, id_mode, m_as);
    if (e_p) chk(prog_addr == a && prog_data == d, {req, " R3 capture"},
                 {prog_addr, prog_data}, {a, d});
  endtask

  task automatic do_rd(input logic [19:0] a, input string req);
    logic [7:0] e = exp_rd(a);
    bit eid = m_as;
    rd_valid = 1; rd_addr = a;
    @(negedge clk);
    rd_valid = 0;
    chk(rd_ack && rd_id == eid && rd_data == e, req, {rd_ack, rd_id, rd_data}, {1'b1, eid, e});
  endtask

  task automatic unlock(input logic [19:0] hi);
    do_wr(hi | 20'h555, 8'hAA, 0, 0, "R1 key1");
    do_wr(hi | 20'h2AA, 8'h55, 0, 0, "R1 key2");
  endtask

  initial begin
    #(CLK_P * 100000);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk({reset_pulse, id_pulse, prog_start, id_mode} == 4'b0, "reset state R12",
        {reset_pulse, id_pulse, prog_start, id_mode}, 0);
    // load protection flags
    for (int b = 0; b < 128; b++) begin
      m_prot[b] = (b % 3 == 0);
      prot_we = 1; prot_blk = 7'(b); prot_set = m_prot[b];
      @(negedge clk);
    end
    prot_we = 0;
    @(negedge clk);
    do_rd(20'h00000, "R10 array read");
    // identifier mode
    unlock(20'h0);
    do_wr(20'h00555, 8'h90, 0, 0, "R1 enter id");
    do_rd(20'h00000, "R8 mfr");
    do_rd(20'h00001, "R8 dev");
    do_rd({7'd3, 13'h0002}, "R9 prot set");
    do_rd({7'd4, 13'h0002}, "R9 prot clear");
    do_rd({7'd3, 13'h0042}, "R11 a6 high");
    do_rd(20'h00003, "R11 a1a0=11");
    // erase blocks return
    do_wr(20'h12345, 8'hF0, 0, 1, "R6 erase");
    do_rd(20'h00000, "R6 still id");
    do_wr(20'h12345, 8'hF0, 0, 0, "R5 bare return");
    do_rd(20'h00001, "R10 after return");
    // high address bits ignored
    unlock(20'hFF000);
    do_wr(20'hA3555, 8'h90, 0, 0, "R2 high bits");
    unlock(20'h5A000);
    do_wr(20'h00777, 8'hF0, 0, 0, "R5 return after keys");
    // program
    unlock(20'h0);
    do_wr(20'h00555, 8'hA0, 0, 0, "R3 arm");
    do_wr(20'hABCDE, 8'h3C, 0, 0, "R3 program");
    unlock(20'h0);
    do_wr(20'h00555, 8'hA0, 1, 0, "R4 busy arm");
    do_wr(20'h11111, 8'h77, 0, 0, "R4 no program");
    // sequence breaks
    do_wr(20'h00555, 8'hAA, 0, 0, "R7 key1");
    do_wr(20'h00555, 8'h90, 0, 0, "R7 bad key2");
    do_wr(20'h002AA, 8'h55, 0, 0, "R7 lone key2");
    do_wr(20'h00555, 8'h90, 0, 0, "R7 lone op");
    unlock(20'h0);
    do_wr(20'h00556, 8'h90, 0, 0, "R7 bad op addr");
    do_wr(20'h00555, 8'hA0, 0, 0, "R7 lone prog");
    // random mix
    for (int i = 0; i < 1500; i++) begin
      int sel = $urandom_range(0, 9);
      logic [19:0] hi = {8'($urandom), 12'h0};
      bit bz = ($urandom_range(0, 7) == 0);
      bit er = ($urandom_range(0, 7) == 0);
      case (sel)
        0, 1: do_wr(hi | 20'h555, 8'hAA, bz, er, "R7 rnd");
        2, 3: do_wr(hi | 20'h2AA, 8'h55, bz, er, "R7 rnd");
        4:    do_wr(hi | 20'h555, 8'h90, bz, er, "R1 rnd");
        5:    do_wr(hi | 20'h555, 8'hA0, bz, er, "R4 rnd");
        6:    do_wr(20'($urandom), 8'hF0, bz, er, "R5 rnd");
        7:    do_wr(20'($urandom), 8'($urandom), bz, er, "R3 rnd");
        default: do_rd(20'($urandom), "R9 rnd");
      endcase
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule